// File: doc/BRIEF.md
# Core Window Switch Controller

A host reaches the cores of a chip through one address window. A single window register chooses which core that window shows. This controller takes a core index and writes the matching window value into that register. It then reads the register back and converts the value into an index again. The switch counts as complete only when the decoded index equals the requested one. If they differ, the controller waits a fixed number of microsecond ticks, writes again, and gives up after a bounded number of attempts. An error on the register path stops the switch at once.

The controller remembers which core is currently mapped. When a request names that same core, no register access is made. A requester presents `req_core` and an access width with `req_valid`. The request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle, so the requester must hold `req_valid`, `req_core` and `req_width` steady until the request is accepted. The result comes back as a one-cycle `done` pulse together with `err` and `fill_data`. That pulse cannot be held off, so the requester must take it in the cycle it appears. On failure, `fill_data` carries the all-ones value that the failed downstream access returns.

The register side uses a plain request/acknowledge scheme. `reg_req` stays high until the cycle in which `reg_ack` is seen. `reg_rdata` and `reg_err` are sampled in that acknowledge cycle.

Top module: `core_window_switch`

## Requirements
- R1: Every register write carries the value BASE_ADDR + core_index * 2^REGION_LOG2 for the core being switched to.
- R2: After a write is acknowledged without error, the controller reads the register. The readback index is (readback - BASE_ADDR) shifted right by REGION_LOG2. If it equals the requested index, the controller pulses `done` with `err` low, and `cur_core`/`cur_valid` then show that core.
- R3: When the readback index differs from the request, the controller waits exactly DELAY_US rising `us_tick` cycles, counted after the read acknowledge. It then writes the same value again.
- R4: An attempt counter starts at zero and is tested before it is incremented at each mismatch. The switch fails with `err` high when a mismatch arrives with the counter above MAX_RETRY, which is after MAX_RETRY+2 writes in total.
- R5: `reg_err` high with `reg_ack`, on either a write or a read, ends the switch at once with `done` and `err` high in the next cycle. No further register access is made.
- R6: On a failed switch, `fill_data` is all ones at the requested width: width 0 gives 0x000000FF, width 1 gives 0x0000FFFF, and widths 2 and 3 give 0xFFFFFFFF. On a successful switch, `fill_data` is 0.
- R7: A request whose index equals `cur_core` while `cur_valid` is high is skipped. `done` rises in the next cycle with `err` low, and no register access is made.
- R8: `cur_valid` is low after reset, so the first request always switches. A failed switch leaves `cur_core` and `cur_valid` unchanged.
- R9: `req_ready` is high only when idle, and no register request is made while idle. During a register request, `reg_we` and `reg_wdata` stay stable until `reg_ack`.
- R10: The readback index is compared over the full register width. A readback that matches the request in its low CORE_W bits but has any higher index bit set counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_core | input | CORE_W | Requested core index |
| req_width | input | 2 | Access width: 0 byte, 1 half-word, 2/3 word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Switch failed, valid with `done` |
| fill_data | output | 32 | All-ones return value on failure, 0 on success; valid with `done` |
| cur_core | output | CORE_W | Index of the core currently mapped |
| cur_valid | output | 1 | `cur_core` holds a confirmed mapping |
| reg_req | output | 1 | Window register access request |
| reg_we | output | 1 | Access is a write (1) or read (0) |
| reg_wdata | output | ADDR_W | Window value to write |
| reg_rdata | input | ADDR_W | Window register readback |
| reg_ack | input | 1 | Access complete |
| reg_err | input | 1 | Access failed, valid with `reg_ack` |
| us_tick | input | 1 | One-cycle pulse each microsecond |

## Verification
The bench builds the controller with a 4 KiB region (REGION_LOG2 = 12), a 5-bit core index, MAX_RETRY = 2 and DELAY_US = 10. It drives a microsecond tick every fourth clock. A retry limit this small makes both outcomes reachable within a few hundred cycles: a switch that succeeds on its last allowed write, and one that fails after four mismatched readbacks. The corrupted readbacks set only an index bit above the 5-bit field, so every retry case also tests the full-width compare. Ten ticks per delay, four clocks apart, let the bench count each wait exactly.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_WAIT  = 2'd3
  } cwin_state_e;

  localparam logic [1:0] ACC_BYTE = 2'd0;
  localparam logic [1:0] ACC_HALF = 2'd1;

  // All-ones return value for a failed access of the given width.
  function automatic logic [31:0] fill_mask(input logic [1:0] width);
    case (width)
      ACC_BYTE: fill_mask = 32'h0000_00FF;
      ACC_HALF: fill_mask = 32'h0000_FFFF;
      default:  fill_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cwin_codec.sv
// Index <-> window value conversion. The region size is a power of two,
// so the division in the decode becomes a right shift.
module cwin_codec #(
  parameter int                 CORE_W      = 5,
  parameter int                 ADDR_W      = 32,
  parameter int                 REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h1800_0000
) (
  input  logic [CORE_W-1:0] core,
  input  logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] wval,
  output logic              match
);
  localparam int PAD_W = ADDR_W - CORE_W;

  logic [ADDR_W-1:0] core_ext;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] decoded;

  assign core_ext = {{PAD_W{1'b0}}, core};
  assign wval     = BASE_ADDR + (core_ext << REGION_LOG2);
  assign offset   = rdata - BASE_ADDR;
  assign decoded  = offset >> REGION_LOG2;
  // Full-width compare: stray upper index bits count as a mismatch.
  assign match    = (decoded == core_ext);
endmodule

// File: rtl/cwin_delay.sv
// Retry wait: counts DELAY_US microsecond ticks after a start pulse.
module cwin_delay #(
  parameter int DELAY_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic expired
);
  generate
    if (DELAY_US == 0) begin : g_nodelay
      always_ff @(posedge clk) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= start;
      end
    end else begin : g_count
      localparam int CNT_W = $clog2(DELAY_US + 1);
      logic [CNT_W-1:0] cnt_q;
      logic             busy_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q   <= '0;
          busy_q  <= 1'b0;
          expired <= 1'b0;
        end else begin
          expired <= 1'b0;
          if (start) begin
            cnt_q  <= CNT_W'(DELAY_US);
            busy_q <= 1'b1;
          end else if (busy_q && tick) begin
            if (cnt_q == CNT_W'(1)) begin
              busy_q  <= 1'b0;
              expired <= 1'b1;
            end
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/core_window_switch.sv
module core_window_switch
  import cwin_pkg::*;
#(
  parameter int                 CORE_W      = 5,
  parameter int                 ADDR_W      = 32,
  parameter int                 REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h1800_0000,
  parameter int                 MAX_RETRY   = 2,
  parameter int                 DELAY_US    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [1:0]        req_width,
  output logic              done,
  output logic              err,
  output logic [31:0]       fill_data,
  output logic [CORE_W-1:0] cur_core,
  output logic              cur_valid,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_rdata,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic              us_tick
);
  localparam int ATT_W = $clog2(MAX_RETRY + 2) + 1;
  localparam logic [ATT_W-1:0] ATT_LIMIT = ATT_W'(MAX_RETRY);

  cwin_state_e       state_q;
  logic [CORE_W-1:0] core_q;
  logic [CORE_W-1:0] map_q;
  logic              map_v_q;
  logic [1:0]        width_q;
  logic [ATT_W-1:0]  att_q;
  logic              done_q;
  logic              err_q;
  logic [31:0]       fill_q;

  logic              match;
  logic [ADDR_W-1:0] win_val;
  logic              dly_expired;

  logic accept, hit, wr_ack, rd_ack, give_up, rd_ok, retry, fail;

  cwin_codec #(
    .CORE_W     (CORE_W),
    .ADDR_W     (ADDR_W),
    .REGION_LOG2(REGION_LOG2),
    .BASE_ADDR  (BASE_ADDR)
  ) u_codec (
    .core (core_q),
    .rdata(reg_rdata),
    .wval (win_val),
    .match(match)
  );

  assign accept  = req_valid && req_ready;
  assign hit     = map_v_q && (req_core == map_q);
  assign wr_ack  = (state_q == ST_WRITE) && reg_ack;
  assign rd_ack  = (state_q == ST_READ) && reg_ack;
  assign give_up = att_q > ATT_LIMIT;
  assign rd_ok   = rd_ack && !reg_err && match;
  assign retry   = rd_ack && !reg_err && !match && !give_up;
  assign fail    = (wr_ack && reg_err) || (rd_ack && (reg_err || (!match && give_up)));

  cwin_delay #(.DELAY_US(DELAY_US)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (retry),
    .tick   (us_tick),
    .expired(dly_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      map_q   <= '0;
      map_v_q <= 1'b0;
      width_q <= '0;
      att_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fill_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            core_q  <= req_core;
            width_q <= req_width;
            att_q   <= '0;
            if (hit) begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
              fill_q <= '0;
            end else begin
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ack && !reg_err) state_q <= ST_READ;
        end
        ST_READ: begin
          if (rd_ok) begin
            map_q   <= core_q;
            map_v_q <= 1'b1;
            done_q  <= 1'b1;
            err_q   <= 1'b0;
            fill_q  <= '0;
            state_q <= ST_IDLE;
          end else if (retry) begin
            att_q   <= att_q + ATT_W'(1);
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dly_expired) state_q <= ST_WRITE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (fail) begin
        done_q  <= 1'b1;
        err_q   <= 1'b1;
        fill_q  <= fill_mask(width_q);
        state_q <= ST_IDLE;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign reg_req   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign reg_we    = (state_q == ST_WRITE);
  assign reg_wdata = win_val;
  assign done      = done_q;
  assign err       = err_q;
  assign fill_data = fill_q;
  assign cur_core  = map_q;
  assign cur_valid = map_v_q;

endmodule

// File: rtl/cwin_checker.sv
module cwin_checker #(
  parameter int                 CORE_W      = 5,
  parameter int                 ADDR_W      = 32,
  parameter int                 REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h1800_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CORE_W-1:0] req_core,
  input logic              done,
  input logic              err,
  input logic [31:0]       fill_data,
  input logic [CORE_W-1:0] cur_core,
  input logic              cur_valid,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              reg_ack,
  input logic              reg_err
);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << REGION_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_LIM  = ADDR_W'(1) << CORE_W;

  logic [ADDR_W-1:0] w_off;
  logic              skip_req;
  assign w_off    = reg_wdata - BASE_ADDR;
  assign skip_req = req_valid && req_ready && cur_valid && (req_core == cur_core);

  // R1: written value is an aligned slot inside the index range
  p_win_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we |-> ((w_off & LOW_MASK) == '0) && ((w_off >> REGION_LOG2) < IDX_LIM));

  // R5: register error aborts in the next cycle
  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_ack && reg_err |=> done && err);

  // R6: fill value on completion
  p_fill_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> fill_data == 32'h0);
  p_fill_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> fill_data[7:0] == 8'hFF);

  // R7: hit on the mapped core completes without access
  p_skip_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |=> done && !err && !reg_req);

  // R8: mapping record moves only with a successful completion
  p_map_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_core) || $rose(cur_valid)) |-> done && !err);

  // R9: idle is quiet, requests held until acknowledged
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !reg_req);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_wdata));

endmodule

bind core_window_switch cwin_checker #(
  .CORE_W     (CORE_W),
  .ADDR_W     (ADDR_W),
  .REGION_LOG2(REGION_LOG2),
  .BASE_ADDR  (BASE_ADDR)
) u_cwin_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_core (req_core),
  .done     (done),
  .err      (err),
  .fill_data(fill_data),
  .cur_core (cur_core),
  .cur_valid(cur_valid),
  .reg_req  (reg_req),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .reg_ack  (reg_ack),
  .reg_err  (reg_err)
);

// File: tb/core_window_switch_test.sv
module core_window_switch_test;
  localparam int          CORE_W      = 5;
  localparam int          ADDR_W      = 32;
  localparam int          REGION_LOG2 = 12;
  localparam logic [31:0] BASE_ADDR   = 32'h1800_0000;
  localparam int          MAX_RETRY   = 2;
  localparam int          DELAY_US    = 10;
  // corrupted readback: same low index bits, one index bit above the field
  localparam logic [31:0] CORRUPT     = 32'h1 << (REGION_LOG2 + CORE_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CORE_W-1:0] req_core = '0;
  logic [1:0] req_width = '0;
  logic done, err;
  logic [31:0] fill_data;
  logic [CORE_W-1:0] cur_core;
  logic cur_valid;
  logic reg_req, reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic reg_ack, reg_err;
  logic us_tick;

  always #10 clk = ~clk;

  core_window_switch #(
    .CORE_W(CORE_W), .ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2),
    .BASE_ADDR(BASE_ADDR), .MAX_RETRY(MAX_RETRY), .DELAY_US(DELAY_US)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_width(req_width), .done(done), .err(err),
    .fill_data(fill_data), .cur_core(cur_core), .cur_valid(cur_valid),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack), .reg_err(reg_err),
    .us_tick(us_tick)
  );

  int nchk = 0;
  int nbad = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- microsecond tick: one pulse every 4 clocks
  logic [1:0] tdiv;
  always @(posedge clk) begin
    if (!rst_n) begin tdiv <= '0; us_tick <= 1'b0; end
    else begin tdiv <= tdiv + 2'd1; us_tick <= (tdiv == 2'd3); end
  end

  // ---------------- window register model
  logic [CORE_W-1:0] v_core = '0;
  int v_bad = 0;
  int v_errm = 0;
  int rd_base = 0;
  logic [31:0] win;
  int nwr, nrd, wr_bad;
  int gap_state, gap_cnt, gaps_seen, gaps_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ack <= 1'b0; reg_err <= 1'b0; reg_rdata <= '0; win <= '0;
      nwr <= 0; nrd <= 0; wr_bad <= 0; gap_state <= 0; gap_cnt <= 0;
    end else begin
      if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        if (reg_we) begin
          win     <= reg_wdata;
          reg_err <= (v_errm == 1);
          nwr     <= nwr + 1;
          if (reg_wdata !== BASE_ADDR + ({27'b0, v_core} << REGION_LOG2)) wr_bad <= wr_bad + 1;
        end else begin
          reg_err <= (v_errm == 2);
          nrd     <= nrd + 1;
          if ((nrd - rd_base) < v_bad) begin
            reg_rdata <= win + CORRUPT;
            if ((nrd - rd_base) <= MAX_RETRY) gap_state <= 1;
          end else begin
            reg_rdata <= win;
          end
        end
      end else begin
        reg_ack <= 1'b0;
        reg_err <= 1'b0;
      end
      if (gap_state == 1) begin
        gap_state <= 2;
        gap_cnt   <= 0;
      end else if (gap_state == 2) begin
        if (reg_req && reg_we) begin
          gap_state <= 0;
          gaps_seen <= gaps_seen + 1;
          if (gap_cnt != DELAY_US) gaps_bad <= gaps_bad + 1;
        end else if (us_tick) begin
          gap_cnt <= gap_cnt + 1;
        end
      end
    end
  end

  initial begin gaps_seen = 0; gaps_bad = 0; end

  // ---------------- vectors: {core5, bad3, errmode2, width2, exp_err1, exp_writes3}
  function automatic logic [15:0] mk(int core, int bad, int errm, int width, int experr, int expwr);
    return {5'(core), 3'(bad), 2'(errm), 2'(width), 1'(experr), 3'(expwr)};
  endfunction

  localparam int NV = 11;
  localparam logic [15:0] VECS [NV] = '{
    mk( 3, 0, 0, 2, 0, 1),   // plain switch
    mk( 3, 0, 0, 2, 0, 0),   // same core: skipped
    mk( 7, 1, 0, 0, 0, 2),   // one retry
    mk( 7, 0, 0, 1, 0, 0),   // skipped
    mk( 9, 3, 0, 2, 0, 4),   // succeeds on last allowed write
    mk(12, 4, 0, 1, 1, 4),   // retries exhausted
    mk( 9, 0, 0, 2, 0, 0),   // record kept after failure: skipped
    mk(12, 0, 1, 0, 1, 1),   // write error
    mk( 5, 0, 2, 2, 1, 1),   // read error
    mk(31, 2, 0, 3, 0, 3),   // top index, two retries
    mk( 0, 0, 0, 0, 0, 1)    // index zero
  };

  logic [CORE_W-1:0] exp_cur = '0;
  logic exp_cv = 1'b0;

  function automatic logic [31:0] exp_fill(input logic [1:0] w, input logic e);
    if (!e) return 32'h0;
    case (w)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic run_req(input logic [CORE_W-1:0] c, input int bad, input int errm,
                         input logic [1:0] w, input logic experr, input int expwr,
                         input string tag);
    int wr_base;
    int guard;
    @(negedge clk);
    v_core = c; v_bad = bad; v_errm = errm;
    rd_base = nrd; wr_base = nwr;
    req_valid = 1'b1; req_core = c; req_width = w;
    @(negedge clk);
    req_valid = 1'b0;
    if (expwr != 0) chk("R9 ready low while switching", {31'b0, req_ready}, 32'd0);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " done seen"}, {31'b0, done}, 32'd1);
    chk({tag, " err"}, {31'b0, err}, {31'b0, experr});
    chk("R6 fill value", fill_data, exp_fill(w, experr));
    chk({tag, " write count"}, nwr - wr_base, expwr);
    if (!experr) begin exp_cur = c; exp_cv = 1'b1; end
    chk("R8 mapped core", {26'b0, cur_valid, cur_core}, {26'b0, exp_cv, exp_cur});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R8, R9)
    chk("R9 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R9 no access after reset", {31'b0, reg_req}, 32'd0);
    chk("R8 no mapping after reset", {31'b0, cur_valid}, 32'd0);
    chk("R2 no done after reset", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      string tag;
      v = VECS[i];
      if (v[2:0] == 3'd0)      tag = "R7";
      else if (v[7:6] != 2'd0) tag = "R5";
      else if (v[3])           tag = "R4";
      else if (v[10:8] != 0)   tag = "R3/R10";
      else                     tag = "R2";
      run_req(v[15:11], int'(v[10:8]), int'(v[7:6]), v[5:4], v[3], int'(v[2:0]), tag);
    end

    @(negedge clk);
    chk("R1 window write values", wr_bad, 0);
    chk("R3 retry waits observed", {31'b0, gaps_seen > 0}, 32'd1);
    chk("R3 wait length in ticks", gaps_bad, 0);

    // reset again: core 0 was mapped, the first request must still switch (R8)
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 mapping cleared by reset", {31'b0, cur_valid}, 32'd0);
    rst_n = 1'b1;
    exp_cv = 1'b0;
    @(negedge clk);
    run_req(5'd0, 0, 0, 2'd2, 1'b0, 1, "R8");
    // retry counter restarts per request: two retries succeed again (R4)
    run_req(5'd4, 2, 0, 2'd0, 1'b0, 3, "R4");
    // byte-width failure after exhausted retries (R6, R4)
    run_req(5'd6, 5, 0, 2'd0, 1'b1, 4, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule